// File: doc/BRIEF.md
# Reverse Linked-List Initialiser

This engine prepares an empty, backward-chained list in word-addressed RAM without processor help. It is given a start byte address and an entry count. It then writes one 32-bit word per clock cycle, walking downward in 4-byte steps. Each word holds the 24-bit address of the word just below it, so software can later walk the chain from the top entry down. The lowest word written carries the all-ones 24-bit end-of-chain marker.

A transfer is launched by a one-cycle start strobe that carries a control word and a channel-enable word. The engine acts on the strobe only when two things hold: the go bit of the control word is set, and the enable bit that belongs to this engine's channel number is set in the enable word. It also has to be idle. The start address is clipped to the RAM size. After the last write the engine holds busy for a fixed number of cycles and then raises a one-cycle done pulse.

Top module: `rev_list_init`

## Requirements
- R1: On a clock edge with `start_i` high, `ctrl_i[24]` high, `chan_en_i[3+4*CHAN]` high (bit 27 for the default channel 6) and the engine idle, the transfer is accepted, and `busy_o` is high from the next cycle.
- R2: A start strobe with `ctrl_i[24]` low starts nothing: no RAM write, and `busy_o` stays low.
- R3: A start strobe whose channel enable bit `chan_en_i[3+4*CHAN]` is low starts nothing, even if other enable bits are set.
- R4: An accepted transfer of N entries writes on the N consecutive cycles right after acceptance. The first address is `base_i` ANDed with (2^RAM_AW − 1), each next address is 4 lower modulo 2^24, and `mem_addr_o` shows the low RAM_AW bits.
- R5: Every entry except the last has data = (its own 24-bit address − 4) mod 2^24, with bits 31:24 zero.
- R6: The last (lowest) entry has data 0x00FFFFFF.
- R7: A count of zero writes nothing, yet still produces the done pulse.
- R8: `done_o` is a one-cycle pulse DONE_DELAY cycles after the last write cycle. With a count of zero, it comes DONE_DELAY−1 cycles after the first busy cycle.
- R9: `busy_o` stays high from acceptance through the done cycle and falls after it. A start strobe that arrives while busy is ignored.
- R10: During and right after reset, `mem_we_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start strobe |
| ctrl_i | input | 32 | Channel control word; bit 24 is the go bit |
| chan_en_i | input | 32 | Priority/enable word; bit 3+4*CHAN enables this channel |
| base_i | input | 24 | Start (highest) byte address |
| count_i | input | 16 | Number of entries to write |
| mem_addr_o | output | RAM_AW | RAM byte address of the current write |
| mem_data_o | output | 32 | Word written to RAM |
| mem_we_o | output | 1 | RAM write enable |
| busy_o | output | 1 | Transfer in progress or waiting for completion |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take three things as given. The start strobe is one cycle wide. `base_i`, `count_i`, `ctrl_i` and `chan_en_i` are stable while the strobe is sampled. DONE_DELAY is at least one. The stimulus drives every strobe for exactly one cycle from the falling edge. It sets the operands in the same falling-edge slot, and it re-strobes during a busy transfer only with a single-cycle pulse. That keeps every start well-formed, while the busy-window and disabled-channel cases are still exercised.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
    typedef enum logic [1:0] {
        RLC_IDLE = 2'd0,
        RLC_FILL = 2'd1,
        RLC_HOLD = 2'd2
    } rlc_state_e;
endpackage

// File: rtl/rlc_start_gate.sv
module rlc_start_gate #(
    parameter int CTRL_W = 32,
    parameter int EN_W   = 32,
    parameter int GO_BIT = 24,
    parameter int CHAN   = 6
) (
    input  logic              start_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [EN_W-1:0]   chan_en_i,
    output logic              req_o
);
    localparam int EN_BIT = 3 + 4 * CHAN;

    logic unused_bits;
    assign unused_bits = ^{ctrl_i, chan_en_i};

    always_comb begin
        req_o = start_i & ctrl_i[GO_BIT] & chan_en_i[EN_BIT];
    end
endmodule

// File: rtl/rlc_hold_timer.sv
module rlc_hold_timer #(
    parameter int DELAY = 2150
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    output logic expire_o
);
    localparam int TW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [TW-1:0] LAST = TW'(DELAY - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = hold_i && (tmr_q.cnt == LAST);
        if (!hold_i || expire_o) tmr_d.cnt = '0;
        else                     tmr_d.cnt = tmr_q.cnt + TW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |-> (int'(tmr_q.cnt) < DELAY));

    assert_cnt_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hold_i |=> (tmr_q.cnt == '0));
endmodule

// File: rtl/rlc_walker.sv
module rlc_walker
    import rlc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int RAM_AW = 21,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              expire_i,
    output logic              hold_o,
    output logic              busy_o,
    output logic [RAM_AW-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              mem_we_o
);
    localparam logic [ADDR_W-1:0] RAM_MASK = ADDR_W'((64'd1 << RAM_AW) - 64'd1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] MARKER   = {ADDR_W{1'b1}};
    localparam int                PAD_W    = DATA_W - ADDR_W;

    typedef struct packed {
        rlc_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  left;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  last_entry;
    logic [ADDR_W-1:0] link;

    always_comb begin
        walk_d     = walk_q;
        last_entry = (walk_q.left == CNT_W'(1));
        link       = last_entry ? MARKER : (walk_q.ptr - STEP);
        unique case (walk_q.st)
            RLC_IDLE: begin
                if (req_i) begin
                    walk_d.ptr  = base_i & RAM_MASK;
                    walk_d.left = count_i;
                    walk_d.st   = (count_i == '0) ? RLC_HOLD : RLC_FILL;
                end
            end
            RLC_FILL: begin
                walk_d.ptr  = walk_q.ptr - STEP;
                walk_d.left = walk_q.left - CNT_W'(1);
                if (last_entry) walk_d.st = RLC_HOLD;
            end
            RLC_HOLD: begin
                if (expire_i) walk_d.st = RLC_IDLE;
            end
            default: walk_d.st = RLC_IDLE;
        endcase
    end

    always_comb begin
        mem_we_o   = (walk_q.st == RLC_FILL);
        mem_addr_o = walk_q.ptr[RAM_AW-1:0];
        mem_data_o = {{PAD_W{1'b0}}, link};
        hold_o     = (walk_q.st == RLC_HOLD);
        busy_o     = (walk_q.st != RLC_IDLE);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            walk_q.st   <= RLC_IDLE;
            walk_q.ptr  <= '0;
            walk_q.left <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o && !last_entry) |=> (mem_we_o && walk_q.ptr == $past(walk_q.ptr) - STEP));

    assert_restart_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && walk_q.st != RLC_HOLD) |=> $stable(walk_q.left) || (walk_q.left == $past(walk_q.left) - CNT_W'(1)));

    assert_hold_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_o && expire_i) |=> (walk_q.st == RLC_IDLE));
endmodule

// File: rtl/rev_list_init.sv
module rev_list_init #(
    parameter int ADDR_W     = 24,
    parameter int RAM_AW     = 21,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 32,
    parameter int CTRL_W     = 32,
    parameter int EN_W       = 32,
    parameter int GO_BIT     = 24,
    parameter int CHAN       = 6,
    parameter int DONE_DELAY = 2150
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [EN_W-1:0]   chan_en_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [RAM_AW-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              mem_we_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int EN_BIT = 3 + 4 * CHAN;

    logic req;
    logic hold;
    logic expire;

    rlc_start_gate #(
        .CTRL_W (CTRL_W),
        .EN_W   (EN_W),
        .GO_BIT (GO_BIT),
        .CHAN   (CHAN)
    ) i_gate (
        .start_i   (start_i),
        .ctrl_i    (ctrl_i),
        .chan_en_i (chan_en_i),
        .req_o     (req)
    );

    rlc_walker #(
        .ADDR_W (ADDR_W),
        .RAM_AW (RAM_AW),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) i_walker (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req),
        .base_i     (base_i),
        .count_i    (count_i),
        .expire_i   (expire),
        .hold_o     (hold),
        .busy_o     (busy_o),
        .mem_addr_o (mem_addr_o),
        .mem_data_o (mem_data_o),
        .mem_we_o   (mem_we_o)
    );

    rlc_hold_timer #(
        .DELAY (DONE_DELAY)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hold_i   (hold),
        .expire_o (expire)
    );

    assign done_o = expire;

    assert_accept_cond_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i && ctrl_i[GO_BIT] && chan_en_i[EN_BIT]));

    assert_we_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> busy_o);

    assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

    assert_last_marker_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_we_o) |-> ($past(mem_data_o) == DATA_W'(32'h00FF_FFFF)));

    assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> (mem_data_o[DATA_W-1:ADDR_W] == '0));
endmodule

// File: tb/test_rev_list_init.sv
module test_rev_list_init;
    localparam int D   = 20;
    localparam int RAW = 21;
    localparam logic [23:0] MASK = 24'((1 << RAW) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctrl = '0;
    logic [31:0] en = '0;
    logic [23:0] base = '0;
    logic [15:0] cnt = '0;
    logic [RAW-1:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_we, busy, done;

    always #10 clk = ~clk;

    rev_list_init #(.RAM_AW(RAW), .DONE_DELAY(D)) i_rev_list_init (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_i(ctrl),
        .chan_en_i(en), .base_i(base), .count_i(cnt),
        .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_we_o(mem_we),
        .busy_o(busy), .done_o(done)
    );

    typedef struct packed {
        logic [RAW-1:0] a;
        logic [31:0]    d;
        logic           last;
    } ent_t;

    ent_t exp_q[$];
    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every RAM write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected write", longint'(mem_addr), 0);
            end else begin
                ent_t e;
                e = exp_q.pop_front();
                chk(mem_addr == e.a, "R4 address", longint'(mem_addr), longint'(e.a));
                chk(mem_data == e.d, e.last ? "R6 terminator" : "R5 link word",
                    longint'(mem_data), longint'(e.d));
            end
        end
    end

    // Driver: queue expected entries, strobe, wait for done
    task automatic fill(input logic [23:0] b, input int n, input int poke);
        logic [23:0] p;
        int e;
        int k;
        p = b & MASK;
        for (int i = 0; i < n; i++) begin
            ent_t x;
            x.a    = p[RAW-1:0];
            x.d    = (i == n - 1) ? 32'h00FF_FFFF : {8'h00, p - 24'd4};
            x.last = (i == n - 1);
            exp_q.push_back(x);
            p = p - 24'd4;
        end
        base  = b;
        cnt   = 16'(n);
        ctrl  = 32'h0100_0000;
        en    = 32'h0800_0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e = cyc;
        chk(busy, "R1 busy after accept", longint'(busy), 1);
        k = 0;
        while (!done && k < 5000) begin
            if (k == poke) begin
                start = 1'b1;
                base  = 24'h001234;
                cnt   = 16'd2;
            end
            if (k == poke + 1) start = 1'b0;
            if (!done) chk(busy, "R9 busy until done", longint'(busy), 1);
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(cyc == e + n + D - 1, n == 0 ? "R7 done timing" : "R8 done timing",
            longint'(cyc - e), longint'(n + D - 1));
        chk(exp_q.size() == 0, "R4 all entries written", longint'(exp_q.size()), 0);
        @(negedge clk);
        chk(!done, "R8 single-cycle done", longint'(done), 0);
        chk(!busy, "R9 busy falls after done", longint'(busy), 0);
    endtask

    task automatic try_ignored(input logic [31:0] c, input logic [31:0] m, input string tag);
        base  = 24'h000400;
        cnt   = 16'd4;
        ctrl  = c;
        en    = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk(!mem_we && !busy, tag, longint'({mem_we, busy}), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_we && !busy && !done, "R10 reset state", longint'({mem_we, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_we && !busy && !done, "R10 after reset", longint'({mem_we, busy, done}), 0);

        fill(24'h000100, 1, -1);
        fill(24'h001000, 3, -1);
        fill(24'hE01FFC, 8, -1);
        fill(24'h000004, 3, -1);
        fill(24'h000200, 0, -1);
        try_ignored(32'h0000_0000, 32'h0800_0000, "R2 go bit clear");
        try_ignored(32'h0100_0000, 32'h0080_0000, "R3 channel disabled");
        fill(24'h000800, 6, 2);
        fill(24'h000100, 2, 8);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule